// File: doc/BRIEF.md
# DRAM Geometry Probe

This block finds how many multiplexed row/column address bits a byte-wide DRAM module really has. It sits above a DRAM access sequencer and owns that sequencer's request port while it runs. It tries a set of candidate widths. The largest width is tried first.

For each candidate width, the block sets the sequencer's address-width input to that width. It then aims at the highest address the width can reach, which is all ones across twice the width. There it writes a fixed sequence of eight byte patterns and reads each one back. The first width whose patterns all read back correctly is the result. If the probe gets down to the floor width without a pass, it reports failure.

With the result, the block reports a capacity in kilobytes. The capacity is four times the square of two raised to the width, doubled when the module has two row-strobe lines. The caller starts the probe with a one-cycle `start` and waits for the one-cycle `done`. The results then hold until the next probe is started.

Top module: `geo_probe`

## Requirements
- R1: Candidate widths are tried from MAX_W (12) downward, one step lower after each failed width. The first width that passes is reported on `det_width`. Widths MAX_W down to MIN_W+1 (9) are the only ones tried.
- R2: Every request carries `req_addr` = 2^(2·`addr_width`) − 1, where `addr_width` is the width currently under test.
- R3: The patterns are used in the order 0xF0, 0x0F, 0xAA, 0x55, 0xC0, 0x30, 0x0C, 0x03. Each pattern is one write (`req_wr`=1, `req_wdata` = pattern) followed by one read (`req_wr`=0) of the same address. Every width starts at the first pattern.
- R4: When a read returns a byte that differs from the pattern, that width fails at once. No further patterns are tried at that width. A failure at pattern index k costs 2·(k+1) requests at that width.
- R5: On success, `det_fail`=0 and `cap_kb` = 2^(2·w) × 4 × lines. Here lines is 2 when `dual_ras`=1 and 1 when `dual_ras`=0, with `dual_ras` sampled at start.
- R6: If width MIN_W+1 also fails, the block reports `det_fail`=1, `det_width`=MIN_W (8) and `cap_kb`=0.
- R7: `req_go` pulses for one cycle per request, only while `busy` is high. No new request is issued before `seq_done` has answered the previous one.
- R8: `det_width`, `det_fail` and `cap_kb` stay constant from `done` until the next accepted start. A `start` pulse while `busy` is high is ignored.
- R9: `done` is a single-cycle pulse. Reset puts the block in its idle state, with `busy`, `done`, `req_go`, `det_fail`, `det_width` and `cap_kb` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a probe when idle |
| dual_ras | input | 1 | 1 when the module has two row-strobe lines |
| req_go | output | 1 | One-cycle request strobe to the sequencer |
| req_wr | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | 2·MAX_W | Linear address for the request |
| req_wdata | output | 8 | Byte to write |
| addr_width | output | $clog2(MAX_W+1) | Address-width setting for the sequencer |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_rdata | input | 8 | Read byte, valid with `seq_done` |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle end-of-probe pulse |
| det_width | output | $clog2(MAX_W+1) | Detected address width |
| det_fail | output | 1 | No candidate width passed |
| cap_kb | output | 2·MAX_W+4 | Capacity in kilobytes |

## Verification
The hardest case to reach from the ports is a width that fails partway through its pattern list. A top address that is simply out of range fails on the first pattern and never reaches this path. The bench's sequencer model therefore stores the last written byte and answers reads at in-range addresses correctly. It can also corrupt a single chosen pattern, but only at one chosen width. The early abort then shows up as an exact request count, and the fallback to the next width shows up as a smaller detected width. The model also checks every request against the expected address, pattern order and one-outstanding rule as it arrives.

// File: rtl/geo_pkg.sv
package geo_pkg;

  localparam int PAT_COUNT = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_ISSUE,
    ST_WR_WAIT,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_FINISH
  } probe_state_t;

  // Test byte for a given step of the sequence; order matters.
  function automatic logic [7:0] probe_pattern(input logic [2:0] idx);
    logic [7:0] p;
    case (idx)
      3'd0:    p = 8'hF0;
      3'd1:    p = 8'h0F;
      3'd2:    p = 8'hAA;
      3'd3:    p = 8'h55;
      3'd4:    p = 8'hC0;
      3'd5:    p = 8'h30;
      3'd6:    p = 8'h0C;
      default: p = 8'h03;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/geo_pattern_seq.sv
module geo_pattern_seq
  import geo_pkg::*;
#(
  parameter int COUNT = PAT_COUNT,
  localparam int IDX_W = $clog2(COUNT)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       advance,
  output logic [7:0] pattern,
  output logic       last
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clear) begin
      idx_d = '0;
    end else if (advance) begin
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clear || advance) begin
      idx_q <= idx_d;
    end
  end

  assign pattern = probe_pattern(3'(idx_q));
  assign last    = (idx_q == IDX_W'(COUNT - 1));

  // R3: the index only ever stays, steps up by one, or returns to the first pattern
  assert_pattern_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != '0) |-> ((idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + IDX_W'(1))));

endmodule

// File: rtl/geo_width_walk.sv
module geo_width_walk #(
  parameter int MAX_W = 12,
  parameter int MIN_W = 8,
  localparam int W_BITS = $clog2(MAX_W + 1),
  localparam int ADDR_W = 2 * MAX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [W_BITS-1:0] width,
  output logic              at_floor,
  output logic [ADDR_W-1:0] top_addr
);

  logic [W_BITS-1:0] width_q;
  logic [W_BITS-1:0] width_d;

  always_comb begin
    width_d = width_q;
    if (load) begin
      width_d = W_BITS'(MAX_W);
    end else if (step) begin
      width_d = width_q - W_BITS'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= W_BITS'(MAX_W);
    end else if (load || step) begin
      width_q <= width_d;
    end
  end

  assign width    = width_q;
  assign at_floor = (width_q == W_BITS'(MIN_W + 1));

  // Highest address of a width w: the low 2*w bits set.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_top_bit
    assign top_addr[b] = (W_BITS'(b / 2) < width_q);
  end

  // R1: the tried width never leaves the candidate range
  assert_width_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q > W_BITS'(MIN_W)) && (width_q <= W_BITS'(MAX_W)));

endmodule

// File: rtl/geo_capacity.sv
module geo_capacity #(
  parameter int MAX_W = 12,
  localparam int W_BITS = $clog2(MAX_W + 1),
  localparam int CAP_W = 2 * MAX_W + 4
) (
  input  logic [W_BITS-1:0] width,
  input  logic              dual_lines,
  input  logic              none_found,
  output logic [CAP_W-1:0]  kb
);

  logic [W_BITS+1:0] shamt;
  logic [CAP_W-1:0]  base;

  always_comb begin
    shamt = {1'b0, width, 1'b0} + (W_BITS + 2)'(2);
    base  = dual_lines ? CAP_W'(2) : CAP_W'(1);
    kb    = none_found ? '0 : (base << shamt);
  end

endmodule

// File: rtl/geo_probe.sv
module geo_probe
  import geo_pkg::*;
#(
  parameter int MAX_W = 12,
  parameter int MIN_W = 8,
  localparam int W_BITS = $clog2(MAX_W + 1),
  localparam int ADDR_W = 2 * MAX_W,
  localparam int CAP_W = 2 * MAX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dual_ras,
  output logic              req_go,
  output logic              req_wr,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  output logic [W_BITS-1:0] addr_width,
  input  logic              seq_done,
  input  logic [7:0]        seq_rdata,
  output logic              busy,
  output logic              done,
  output logic [W_BITS-1:0] det_width,
  output logic              det_fail,
  output logic [CAP_W-1:0]  cap_kb
);

  probe_state_t state_q;
  probe_state_t state_d;

  logic              pat_clear;
  logic              pat_adv;
  logic              pat_last;
  logic [7:0]        pattern;
  logic              w_load;
  logic              w_step;
  logic              w_floor;
  logic [W_BITS-1:0] width;
  logic [ADDR_W-1:0] top_addr;
  logic              res_load;
  logic              res_none;
  logic              rd_match;
  logic              ras_q;
  logic [CAP_W-1:0]  cap_calc;
  logic [W_BITS-1:0] det_width_q;
  logic              det_fail_q;
  logic [CAP_W-1:0]  cap_q;

  geo_pattern_seq #(.COUNT(PAT_COUNT)) u_patterns (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (pat_clear),
    .advance (pat_adv),
    .pattern (pattern),
    .last    (pat_last)
  );

  geo_width_walk #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_widths (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (w_load),
    .step     (w_step),
    .width    (width),
    .at_floor (w_floor),
    .top_addr (top_addr)
  );

  geo_capacity #(.MAX_W(MAX_W)) u_capacity (
    .width      (width),
    .dual_lines (ras_q),
    .none_found (res_none),
    .kb         (cap_calc)
  );

  assign rd_match = (seq_rdata == pattern);

  // Next-state and control decode
  always_comb begin
    state_d   = state_q;
    pat_clear = 1'b0;
    pat_adv   = 1'b0;
    w_load    = 1'b0;
    w_step    = 1'b0;
    res_load  = 1'b0;
    res_none  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_WR_ISSUE;
          pat_clear = 1'b1;
          w_load    = 1'b1;
        end
      end
      ST_WR_ISSUE: state_d = ST_WR_WAIT;
      ST_WR_WAIT: begin
        if (seq_done) begin
          state_d = ST_RD_ISSUE;
        end
      end
      ST_RD_ISSUE: state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (seq_done) begin
          if (rd_match) begin
            if (pat_last) begin
              state_d  = ST_FINISH;
              res_load = 1'b1;
            end else begin
              state_d = ST_WR_ISSUE;
              pat_adv = 1'b1;
            end
          end else begin
            pat_clear = 1'b1;
            if (w_floor) begin
              state_d  = ST_FINISH;
              res_load = 1'b1;
              res_none = 1'b1;
            end else begin
              state_d = ST_WR_ISSUE;
              w_step  = 1'b1;
            end
          end
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Line-count option captured on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b0;
    end else if ((state_q == ST_IDLE) && start) begin
      ras_q <= dual_ras;
    end
  end

  // Result registers, written once per probe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_width_q <= '0;
      det_fail_q  <= 1'b0;
      cap_q       <= '0;
    end else if (res_load) begin
      det_width_q <= res_none ? W_BITS'(MIN_W) : width;
      det_fail_q  <= res_none;
      cap_q       <= cap_calc;
    end
  end

  assign req_go     = (state_q == ST_WR_ISSUE) || (state_q == ST_RD_ISSUE);
  assign req_wr     = (state_q == ST_WR_ISSUE);
  assign req_addr   = top_addr;
  assign req_wdata  = pattern;
  assign addr_width = width;
  assign busy       = (state_q != ST_IDLE) && (state_q != ST_FINISH);
  assign done       = (state_q == ST_FINISH);
  assign det_width  = det_width_q;
  assign det_fail   = det_fail_q;
  assign cap_kb     = cap_q;

  // R7: a request strobe never repeats on the next cycle
  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_go |=> !req_go);

  // R7: requests only while a probe runs
  assert_req_in_probe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_go |-> busy);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: results hold while idle and no start arrives
  assert_hold_results_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(det_width) && $stable(det_fail) && $stable(cap_kb)));

  // R6: a failed probe reports the floor width and no capacity
  assert_fail_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && det_fail) |-> ((det_width == W_BITS'(MIN_W)) && (cap_kb == '0)));

  // R5: a successful capacity is a power of two
  assert_cap_power_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !det_fail) |-> ($countones(cap_kb) == 1));

endmodule

// File: tb/test_geo_probe.sv
module test_geo_probe;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_W      = 12;
  localparam int MIN_W      = 8;
  localparam int W_BITS     = 4;
  localparam int ADDR_W     = 24;
  localparam int CAP_W      = 28;
  localparam int WATCHDOG   = 100000;

  localparam logic [7:0] PATS [8] = '{8'hF0, 8'h0F, 8'hAA, 8'h55, 8'hC0, 8'h30, 8'h0C, 8'h03};

  typedef struct packed {
    logic [3:0]  tw;
    logic        ras2;
    logic [3:0]  cidx;
    logic [3:0]  ew;
    logic        ef;
    logic [31:0] ecap;
    logic [7:0]  ereq;
  } vec_t;

  // true width, two lines, corrupted pattern index (8 = none) -> width, fail, capacity, requests
  localparam vec_t VECS [7] = '{
    '{4'd12, 1'b0, 4'd8, 4'd12, 1'b0, 32'd67108864, 8'd16},
    '{4'd10, 1'b1, 4'd8, 4'd10, 1'b0, 32'd8388608,  8'd20},
    '{4'd11, 1'b0, 4'd3, 4'd10, 1'b0, 32'd4194304,  8'd26},
    '{4'd9,  1'b0, 4'd8, 4'd9,  1'b0, 32'd1048576,  8'd22},
    '{4'd8,  1'b1, 4'd8, 4'd8,  1'b1, 32'd0,        8'd8},
    '{4'd12, 1'b1, 4'd7, 4'd11, 1'b0, 32'd33554432, 8'd32},
    '{4'd9,  1'b0, 4'd0, 4'd8,  1'b1, 32'd0,        8'd8}
  };

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              dual_ras;
  logic              req_go;
  logic              req_wr;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0]        req_wdata;
  logic [W_BITS-1:0] addr_width;
  logic              seq_done;
  logic [7:0]        seq_rdata;
  logic              busy;
  logic              done;
  logic [W_BITS-1:0] det_width;
  logic              det_fail;
  logic [CAP_W-1:0]  cap_kb;

  geo_probe #(.MAX_W(MAX_W), .MIN_W(MIN_W)) i_geo_probe (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dual_ras   (dual_ras),
    .req_go     (req_go),
    .req_wr     (req_wr),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .addr_width (addr_width),
    .seq_done   (seq_done),
    .seq_rdata  (seq_rdata),
    .busy       (busy),
    .done       (done),
    .det_width  (det_width),
    .det_fail   (det_fail),
    .cap_kb     (cap_kb)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // memory model knobs and state
  int          true_w      = 12;
  int          corrupt_idx = 8;
  int          req_count   = 0;
  int          exp_idx     = 0;
  bit          resp_due    = 0;
  bit          outstanding = 0;
  bit          expect_read = 0;
  logic [23:0] last_addr   = '0;
  logic [7:0]  last_data   = '0;
  logic [7:0]  resp_data   = '0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Sequencer model: answers each request one cycle later and checks it
  initial begin
    seq_done  = 1'b0;
    seq_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        seq_done    = 1'b0;
        resp_due    = 0;
        outstanding = 0;
        expect_read = 0;
      end else begin
        bit prev_out;
        prev_out = outstanding;
        seq_done = 1'b0;
        if (resp_due) begin
          seq_done    = 1'b1;
          seq_rdata   = resp_data;
          resp_due    = 0;
          outstanding = 0;
        end
        if (req_go) begin
          logic [31:0] exp_a;
          req_count++;
          check(!prev_out, "R7 request while one outstanding", prev_out, 0);
          check(busy, "R7 request outside a probe", busy, 1);
          exp_a = (32'd1 << (2 * int'(addr_width))) - 32'd1;
          check({8'd0, req_addr} == exp_a, "R2 request address", req_addr, exp_a);
          if (req_wr) begin
            check(req_wdata == PATS[exp_idx], "R3 write pattern order", req_wdata, PATS[exp_idx]);
            check(!expect_read, "R3 write without readback", expect_read, 0);
            last_addr   = req_addr;
            last_data   = req_wdata;
            expect_read = 1;
            resp_data   = 8'h00;
          end else begin
            logic [7:0] rd;
            check(expect_read && (req_addr == last_addr), "R3 read of written address",
                  req_addr, last_addr);
            if ({8'd0, req_addr} < (32'd1 << (2 * true_w))) rd = last_data;
            else rd = ~last_data;
            if ((int'(addr_width) == true_w) && (corrupt_idx < 8) &&
                (last_data == PATS[corrupt_idx])) rd = rd ^ 8'h01;
            resp_data   = rd;
            exp_idx     = (rd == last_data) ? (exp_idx + 1) % 8 : 0;
            expect_read = 0;
          end
          resp_due    = 1;
          outstanding = 1;
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    summary();
    $finish;
  end

  task automatic run_probe(input int tw, input bit ras2, input int cidx, input bit poke);
    true_w      = tw;
    corrupt_idx = cidx;
    dual_ras    = ras2;
    req_count   = 0;
    exp_idx     = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (9) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    dual_ras = ~ras2;
    while (!done) @(negedge clk);
  endtask

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    dual_ras = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !done && !req_go, "R9 reset control outputs", {busy, done, req_go}, 0);
    check(det_width == 0 && !det_fail && cap_kb == 0, "R9 reset results", det_width, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !req_go, "R9 idle after reset", busy, 0);

    // vector table
    for (int v = 0; v < 7; v++) begin
      run_probe(int'(VECS[v].tw), VECS[v].ras2, int'(VECS[v].cidx), 1'b0);
      check(det_width == VECS[v].ew, "R1 detected width", det_width, VECS[v].ew);
      check(det_fail == VECS[v].ef, "R6 fail flag", det_fail, VECS[v].ef);
      check({4'd0, cap_kb} == VECS[v].ecap, "R5 capacity", cap_kb, VECS[v].ecap);
      check(req_count == int'(VECS[v].ereq), "R4 request count", req_count, VECS[v].ereq);
      @(negedge clk);
      check(!done, "R9 done lasts one cycle", done, 0);
    end

    // R8: results hold with no start while other inputs move
    begin
      logic [W_BITS-1:0] w0;
      logic [CAP_W-1:0]  c0;
      logic              f0;
      int                r0;
      run_probe(10, 1'b1, 8, 1'b0);
      w0 = det_width; c0 = cap_kb; f0 = det_fail; r0 = req_count;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        dual_ras = ~dual_ras;
      end
      check(det_width == w0 && cap_kb == c0 && det_fail == f0, "R8 results stable", cap_kb, c0);
      check(req_count == r0 && !busy, "R8 no activity without start", req_count, r0);
    end

    // R8: start during a probe is ignored
    run_probe(10, 1'b1, 8, 1'b1);
    check(req_count == 20, "R8 start while busy ignored (requests)", req_count, 20);
    check(det_width == 10 && cap_kb == 28'd8388608, "R8 start while busy ignored (result)",
          cap_kb, 8388608);
    repeat (10) @(negedge clk);
    check(!busy && req_count == 20, "R8 no second probe after busy start", req_count, 20);

    // R9: reset in the middle of a probe
    true_w = 12; corrupt_idx = 8; req_count = 0; exp_idx = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!busy && !req_go && !done, "R9 async reset mid-probe", busy, 0);
    check(det_width == 0 && cap_kb == 0 && !det_fail, "R9 results cleared by reset", cap_kb, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy, "R9 stays idle after reset", busy, 0);

    // R1: probe still correct after a mid-run reset
    run_probe(11, 1'b0, 8, 1'b0);
    check(det_width == 11 && req_count == 18, "R1 width after reset", det_width, 11);

    summary();
    $finish;
  end

endmodule